// File: doc/BRIEF.md
# Pulse-and-Verify Programming Sequencer

This block drives a one-time-writable byte memory through a complete programming pass. A single `start_i` pulse launches the job. The block walks every address from zero to the last one. For each address it fetches the wanted byte from an image source. It then applies program pulses of fixed length and reads the cell back after each pulse. It stops pulsing when the read-back matches or when a retry ceiling is reached. Bytes that equal the erased value need no pulses and are passed over in this phase.

When the last address is done, the block changes the supply selection to the verify level and reads the whole array once more, comparing each location with the image. The outcome is reported on `done_o` and `error_o`. When a failure is found, the address that caused it is held on `fail_addr_o`. The pulse length is derived from a clock-frequency parameter so that a pulse lasts 100 µs. The supply outputs are select levels only; a separate supply circuit turns them into voltages.

Top module: `prog_seq`

## Requirements
- R1: Each program pulse holds `dev_ce_no`=0 and `dev_oe_no`=1 for exactly PULSE_CYC = CLK_HZ/10000 consecutive clocks (100 µs), with `vpp_en_o`=1 and `vcc_hi_o`=1.
- R2: Every pulse is followed by a read-back (`dev_ce_no`=0, `dev_oe_no`=0). Between the end of the pulse and the read-back there is at least one clock with both `dev_ce_no` and `dev_oe_no` high.
- R3: When the read-back differs from the target byte, another pulse is issued. An address that needs N pulses (N ≤ MAX_TRIES) receives exactly N pulses and ends up holding the target byte.
- R4: Addresses are pulsed and verified in ascending order from 0 to 2^ADDR_W-1.
- R5: An address whose target byte is 8'hFF receives no pulse.
- R6: If the read-back still differs after MAX_TRIES pulses, the block does the following: it sets `error_o`; it latches that address on `fail_addr_o`; it issues no further pulse or read; and it raises `done_o`.
- R7: While pulsing and reading back, `vcc_hi_o`=1, `vpp_en_o`=1 and `vfy_sup_o`=0. During the final verify, `vfy_sup_o`=1, `vcc_hi_o`=0 and `vpp_en_o`=0.
- R8: After the last address, the block reads every address once in ascending order under the verify supply. If all of them match, it ends with `done_o`=1 and `error_o`=0.
- R9: At the first final-verify mismatch, the block latches that address on `fail_addr_o`, stops the verify, and raises `done_o` and `error_o` in the same cycle.
- R10: After reset, `done_o`=0, `error_o`=0, `dev_ce_no`=1, `dev_oe_no`=1, and all supply selects are 0. `done_o` and `error_o` hold until the next `start_i`, which clears both in the following cycle.
- R11: `img_req_o` stays high with `img_addr_o` unchanged until `img_valid_i`. One fetch is made per address in each phase, so a clean pass makes 2·2^ADDR_W fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a programming pass |
| done_o | output | 1 | Pass finished (held) |
| error_o | output | 1 | Pass failed (held) |
| fail_addr_o | output | ADDR_W | Address of the failure |
| img_req_o | output | 1 | Image byte request |
| img_addr_o | output | ADDR_W | Address of the requested image byte |
| img_valid_i | input | 1 | Image byte present on img_data_i |
| img_data_i | input | DATA_W | Image byte |
| dev_addr_o | output | ADDR_W | Memory address |
| dev_wdata_o | output | DATA_W | Byte driven to the memory while pulsing |
| dev_rdata_i | input | DATA_W | Byte read from the memory |
| dev_ce_no | output | 1 | Chip enable, active low |
| dev_oe_no | output | 1 | Output enable, active low |
| vpp_en_o | output | 1 | Programming supply on |
| vcc_hi_o | output | 1 | Core supply at raised programming level |
| vfy_sup_o | output | 1 | Both supplies at verify level |

## Verification
The assertions assume three things about the inputs. First, `img_valid_i` arrives only while `img_req_o` is high and lasts a single cycle. Second, `dev_rdata_i` is settled in the same cycle as a read strobe. Third, `start_i` is raised only while the block is idle or finished. The bench respects all three. Its image responder answers each request once, after a random delay of one to three cycles. Its memory model is combinational on the read strobes. It pulses `start_i` only after `done_o` has been seen.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_PULSE, ST_GAP, ST_READ, ST_VFETCH, ST_VREAD, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/pst_pulse_timer.sv
module pst_pulse_timer #(
  parameter int CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);
  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == CW'(CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pst_try_ctr.sv
module pst_try_ctr #(
  parameter int MAX = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_max_o
);
  localparam int CW = $clog2(MAX + 1);
  logic [CW-1:0] cnt_q;

  assign at_max_o = (cnt_q == CW'(MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !at_max_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pst_addr_ctr.sv
module pst_addr_ctr #(
  parameter int AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;

  assign addr_o = addr_q;
  assign last_o = &addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (inc_i)  addr_q <= addr_q + 1'b1;
  end
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int CLK_HZ    = 50_000_000,
  parameter int MAX_TRIES = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              done_o,
  output logic              error_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic              img_req_o,
  output logic [ADDR_W-1:0] img_addr_o,
  input  logic              img_valid_i,
  input  logic [DATA_W-1:0] img_data_i,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic [DATA_W-1:0] dev_wdata_o,
  input  logic [DATA_W-1:0] dev_rdata_i,
  output logic              dev_ce_no,
  output logic              dev_oe_no,
  output logic              vpp_en_o,
  output logic              vcc_hi_o,
  output logic              vfy_sup_o
);
  // 100 us = CLK_HZ / 10000 clocks
  localparam int PULSE_CYC = (CLK_HZ / 10000 < 1) ? 1 : CLK_HZ / 10000;
  localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

  seq_state_e state_q, state_d;
  logic [DATA_W-1:0] tgt_q;
  logic [ADDR_W-1:0] addr, fail_q;
  logic err_q;
  logic last, expire, at_max;
  logic addr_clr, addr_inc, try_clr, try_inc, tgt_ld, fail_set, run_clr;

  pst_addr_ctr #(.AW(ADDR_W)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(addr_clr), .inc_i(addr_inc),
    .addr_o(addr), .last_o(last));

  pst_try_ctr #(.MAX(MAX_TRIES)) u_try (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(try_clr), .inc_i(try_inc),
    .at_max_o(at_max));

  pst_pulse_timer #(.CYC(PULSE_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(state_q == ST_PULSE),
    .expire_o(expire));

  always_comb begin
    state_d  = state_q;
    addr_clr = 1'b0;
    addr_inc = 1'b0;
    try_clr  = 1'b0;
    try_inc  = 1'b0;
    tgt_ld   = 1'b0;
    fail_set = 1'b0;
    run_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) begin
        run_clr  = 1'b1;
        addr_clr = 1'b1;
        state_d  = ST_FETCH;
      end
      ST_FETCH: if (img_valid_i) begin
        tgt_ld = 1'b1;
        if (img_data_i == ERASED) begin
          if (last) begin addr_clr = 1'b1; state_d = ST_VFETCH; end
          else      begin addr_inc = 1'b1; state_d = ST_FETCH;  end
        end else begin
          try_clr = 1'b1;
          state_d = ST_PULSE;
        end
      end
      ST_PULSE: if (expire) begin
        try_inc = 1'b1;
        state_d = ST_GAP;
      end
      ST_GAP: state_d = ST_READ;
      ST_READ: begin
        if (dev_rdata_i == tgt_q) begin
          if (last) begin addr_clr = 1'b1; state_d = ST_VFETCH; end
          else      begin addr_inc = 1'b1; state_d = ST_FETCH;  end
        end else if (at_max) begin
          fail_set = 1'b1;
          state_d  = ST_DONE;
        end else begin
          state_d = ST_PULSE;
        end
      end
      ST_VFETCH: if (img_valid_i) begin
        tgt_ld  = 1'b1;
        state_d = ST_VREAD;
      end
      ST_VREAD: begin
        if (dev_rdata_i != tgt_q) begin
          fail_set = 1'b1;
          state_d  = ST_DONE;
        end else if (last) begin
          state_d = ST_DONE;
        end else begin
          addr_inc = 1'b1;
          state_d  = ST_VFETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tgt_q   <= ERASED;
      err_q   <= 1'b0;
      fail_q  <= '0;
    end else begin
      state_q <= state_d;
      if (tgt_ld) tgt_q <= img_data_i;
      if (run_clr) begin
        err_q  <= 1'b0;
        fail_q <= '0;
      end else if (fail_set) begin
        err_q  <= 1'b1;
        fail_q <= addr;
      end
    end
  end

  logic prog_ph, vfy_ph;
  assign prog_ph = (state_q == ST_FETCH) || (state_q == ST_PULSE) ||
                   (state_q == ST_GAP)   || (state_q == ST_READ);
  assign vfy_ph  = (state_q == ST_VFETCH) || (state_q == ST_VREAD);

  assign done_o      = (state_q == ST_DONE);
  assign error_o     = err_q;
  assign fail_addr_o = fail_q;
  assign img_req_o   = (state_q == ST_FETCH) || (state_q == ST_VFETCH);
  assign img_addr_o  = addr;
  assign dev_addr_o  = addr;
  assign dev_wdata_o = tgt_q;
  assign dev_ce_no   = !((state_q == ST_PULSE) || (state_q == ST_READ) || (state_q == ST_VREAD));
  assign dev_oe_no   = !((state_q == ST_READ) || (state_q == ST_VREAD));
  assign vpp_en_o    = prog_ph;
  assign vcc_hi_o    = prog_ph;
  assign vfy_sup_o   = vfy_ph;
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
  parameter int ADDR_W    = 15,
  parameter int PULSE_CYC = 5000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              error_o,
  input logic              img_req_o,
  input logic              img_valid_i,
  input logic [ADDR_W-1:0] img_addr_o,
  input logic              dev_ce_no,
  input logic              dev_oe_no,
  input logic              vpp_en_o,
  input logic              vcc_hi_o,
  input logic              vfy_sup_o
);
  logic pulse, rd;
  logic [31:0] plen_q;
  assign pulse = !dev_ce_no && dev_oe_no;
  assign rd    = !dev_ce_no && !dev_oe_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    plen_q <= '0;
    else if (pulse) plen_q <= plen_q + 1;
    else            plen_q <= '0;
  end

  // R1
  pulse_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse |-> (vpp_en_o && vcc_hi_o));
  // R1
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse && plen_q != 0) |-> (plen_q == PULSE_CYC));
  // R2
  read_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse |=> !rd);
  // R7
  vfy_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vfy_sup_o |-> (!vpp_en_o && !vcc_hi_o));
  // R6 R9
  err_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> done_o);
  // R10
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (dev_ce_no && dev_oe_no && !vpp_en_o && !vfy_sup_o));
  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (img_req_o && !img_valid_i) |=> (img_req_o && $stable(img_addr_o)));
endmodule

bind prog_seq prog_seq_chk #(.ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .error_o(error_o),
  .img_req_o(img_req_o), .img_valid_i(img_valid_i), .img_addr_o(img_addr_o),
  .dev_ce_no(dev_ce_no), .dev_oe_no(dev_oe_no), .vpp_en_o(vpp_en_o),
  .vcc_hi_o(vcc_hi_o), .vfy_sup_o(vfy_sup_o));

// File: tb/sim_prog_seq.sv
module sim_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 4;
  localparam int NA   = 1 << AW;
  localparam int HZ   = 50_000;
  localparam int PCYC = HZ / 10000;
  localparam int MAXT = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic done, err, img_req, img_valid = 0, ce_n, oe_n, vpp, vhi, vfy;
  logic [AW-1:0] fail_addr, img_addr, dev_addr;
  logic [7:0] img_data = 0, wdata, rdata;

  logic [7:0] image [NA];
  logic [7:0] mem   [NA];
  int need [NA], pcount [NA];
  bit decay [NA];
  int vectors = 0, miscompares = 0, cycles = 0;
  int plen = 0, paddr = 0, last_p = -1, vexp = 0;
  int len_viol = 0, gap_viol = 0, ord_viol = 0, sup_viol = 0, wd_viol = 0;
  int vreads = 0, fetches = 0, dly = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_seq #(.ADDR_W(AW), .DATA_W(8), .CLK_HZ(HZ), .MAX_TRIES(MAXT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done), .error_o(err),
    .fail_addr_o(fail_addr), .img_req_o(img_req), .img_addr_o(img_addr),
    .img_valid_i(img_valid), .img_data_i(img_data), .dev_addr_o(dev_addr),
    .dev_wdata_o(wdata), .dev_rdata_i(rdata), .dev_ce_no(ce_n), .dev_oe_no(oe_n),
    .vpp_en_o(vpp), .vcc_hi_o(vhi), .vfy_sup_o(vfy));

  // memory model: read is combinational on the strobes
  assign rdata = (!ce_n && !oe_n) ?
                 (mem[dev_addr] ^ ((vfy && decay[dev_addr]) ? 8'h01 : 8'h00)) : 8'hFF;

  // image responder with random latency
  always @(posedge clk) begin
    if (img_req && !img_valid) begin
      if (dly == 0) begin
        img_valid <= 1'b1;
        img_data  <= image[img_addr];
        dly       <= int'($urandom % 3);
      end else dly <= dly - 1;
    end else img_valid <= 1'b0;
  end

  // protocol observer
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (img_req && img_valid) fetches++;
      if (!ce_n && oe_n) begin
        if (plen == 0) begin
          paddr = int'(dev_addr);
          if (paddr < last_p) ord_viol++;
          last_p = paddr;
          if (wdata != image[paddr]) wd_viol++;
        end
        plen++;
        if (!vpp || !vhi || vfy) sup_viol++;
      end else if (plen != 0) begin
        if (plen != PCYC) len_viol++;
        if (!(ce_n && oe_n)) gap_viol++;
        pcount[paddr]++;
        if (pcount[paddr] >= need[paddr]) mem[paddr] = mem[paddr] & wdata;
        plen = 0;
      end
      if (!ce_n && !oe_n) begin
        if (vfy) begin
          if (vpp || vhi) sup_viol++;
          if (int'(dev_addr) != vexp) ord_viol++;
          vexp++;
          vreads++;
        end else if (!vpp || !vhi) sup_viol++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic prep();
    for (int a = 0; a < NA; a++) begin
      mem[a] = 8'hFF; pcount[a] = 0; decay[a] = 0; need[a] = 1;
    end
    last_p = -1; vexp = 0; len_viol = 0; gap_viol = 0; ord_viol = 0;
    sup_viol = 0; wd_viol = 0; vreads = 0; fetches = 0;
  endtask

  task automatic run();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_pass(input string tag);
    int bad = 0;
    chk(done && !err, {tag, " R8 done/err"}, {done, err}, 2);
    for (int a = 0; a < NA; a++) begin
      int e = (image[a] == 8'hFF) ? 0 : need[a];
      if (pcount[a] != e || mem[a] != image[a]) bad++;
    end
    chk(bad == 0, {tag, " R3 R5 pulses/contents"}, bad, 0);
    chk(len_viol == 0, {tag, " R1 pulse length"}, len_viol, 0);
    chk(gap_viol == 0, {tag, " R2 idle gap"}, gap_viol, 0);
    chk(ord_viol == 0, {tag, " R4 order"}, ord_viol, 0);
    chk(sup_viol == 0 && wd_viol == 0, {tag, " R7 supplies"}, sup_viol + wd_viol, 0);
    chk(vreads == NA, {tag, " R8 verify reads"}, vreads, NA);
    chk(fetches == 2 * NA, {tag, " R11 fetches"}, fetches, 2 * NA);
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    miscompares++;
    $display("FAIL watchdog act=%0d exp=<150000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    prep();
    for (int a = 0; a < NA; a++) image[a] = 8'hFF;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!done && !err && ce_n && oe_n && !vpp && !vhi && !vfy, "R10 reset",
        {done, err, ce_n, oe_n, vpp, vhi, vfy}, 7'b0011000);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // all erased: R5
    prep(); for (int a = 0; a < NA; a++) image[a] = 8'hFF;
    run(); check_pass("erased");

    // random images
    for (int it = 0; it < 4; it++) begin
      prep();
      for (int a = 0; a < NA; a++) begin
        image[a] = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
        need[a]  = 1 + int'($urandom % MAXT);
      end
      run(); check_pass("random");
    end

    // boundary: exactly MAX_TRIES pulses succeed (R3)
    prep();
    for (int a = 0; a < NA; a++) image[a] = 8'($urandom) & 8'h7F;
    need[0] = MAXT; need[NA-1] = MAXT;
    run(); check_pass("max_ok");

    // R6 pulse limit exceeded at address 6
    prep();
    for (int a = 0; a < NA; a++) image[a] = 8'($urandom) & 8'h7F;
    need[6] = MAXT + 1;
    run();
    chk(done && err, "R6 done+error", {done, err}, 3);
    chk(fail_addr == 4'd6, "R6 fail addr", fail_addr, 6);
    chk(pcount[6] == MAXT, "R6 pulses at failing addr", pcount[6], MAXT);
    begin
      int later = 0;
      for (int a = 7; a < NA; a++) later += pcount[a];
      chk(later == 0 && vreads == 0, "R6 stopped", later + vreads, 0);
    end

    // R9 final verify mismatch at 3 and 9
    prep();
    for (int a = 0; a < NA; a++) image[a] = 8'($urandom) & 8'h7F;
    decay[3] = 1; decay[9] = 1;
    run();
    chk(done && err, "R9 done+error", {done, err}, 3);
    chk(fail_addr == 4'd3, "R9 first failing addr", fail_addr, 3);
    chk(vreads == 4, "R9 verify stopped", vreads, 4);

    // R10 hold, then restart clears
    repeat (5) @(negedge clk);
    chk(done && err && fail_addr == 4'd3, "R10 hold", {done, err}, 3);
    prep();
    for (int a = 0; a < NA; a++) image[a] = 8'($urandom);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(!done && !err, "R10 start clears", {done, err}, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
    check_pass("rerun");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule